// File: doc/BRIEF.md
# Slope-Triggered Pulse Capture for a Fast Digitizer Channel

This block watches one channel of a fast photomultiplier sample stream. For each accepted sample it subtracts the sample taken a programmable number of accepted samples earlier. It fires when that slope value is larger than the channel's threshold. Triggering on the rise, and not on absolute amplitude, keeps the decision independent of a slowly drifting baseline.

On a firing the block emits one packet and then ignores further firings until that packet's window has closed. The packet starts with a header word that holds the channel number and a sample-count time stamp. Data words follow, each holding two samples. The window covers a programmable number of samples from before the firing, taken from the same short history that feeds the slope calculation, and a programmable number of samples from the firing sample onward. Samples outside a window are never written out, so quiet baseline is dropped before it reaches the packet FIFO that follows.

With the last word of each packet the block also reports the largest sample seen after the firing and the pulse width.

Top module: `pm_disc`

## Requirements
- R1: For each accepted sample x(i) the block forms d = x(i) − x(i−n), with n = cfg_gap (1..MAX_GAP). The history reads as zero after reset. The block fires only when d is strictly greater than cfg_thresh, so d equal to the threshold does not fire.
- R2: On a firing, the block emits a header word with out_hdr=1 in the cycle after the firing sample is clocked in. out_data[23:16] holds chan_id. out_data[15:0] holds the zero-based count of accepted samples before the firing sample, modulo 2^16.
- R3: The window emits the samples x(i−pre) to x(i+post−1) in time order, where pre = cfg_pre and post = cfg_post. They are packed two per word: the earlier sample goes in out_data[23:12] and the later sample in out_data[11:0].
- R4: When pre+post is odd, the final word holds the last sample in out_data[23:12] and zeros in out_data[11:0].
- R5: out_last is 1 on the final data word of a packet and 0 on all other words, including the header.
- R6: The block cannot fire again while a window is open. It can fire on the first sample after the window's last sample.
- R7: meas_valid pulses together with the final word. meas_peak is then the largest of x(i) to x(i+post−1).
- R8: meas_width is the number of consecutive samples, starting at the firing sample, for which d > cfg_thresh. It is capped at pre+post.
- R9: Samples outside a window produce no output. Cycles with smp_valid=0 are ignored: they produce no output and do not advance the history or the time stamp.
- R10: During and right after reset, out_valid and meas_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_id | input | 8 | Channel number placed in headers |
| cfg_gap | input | 4 | Slope distance n, 1..8 |
| cfg_thresh | input | 12 | Firing threshold on the slope |
| cfg_pre | input | 3 | Samples kept before the firing, 0..7 |
| cfg_post | input | 8 | Samples kept from the firing on, 2..255 |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 12 | Unsigned sample |
| out_valid | output | 1 | Output word strobe |
| out_hdr | output | 1 | Word is a header |
| out_last | output | 1 | Word is the last one of a packet |
| out_data | output | 24 | Header or packed sample pair |
| meas_valid | output | 1 | Measurement strobe |
| meas_peak | output | 12 | Maximum height after the firing |
| meas_width | output | 9 | Pulse width in samples |

## Verification
The assertions assume that cfg_post is at least 2, that cfg_gap is within 1..MAX_GAP, and that no setting changes while a window is open. Under those conditions a header never shares a cycle with the final word, and the packet framing is well formed. The stimulus changes settings only after enough baseline samples for any window to close. It always sets post of 2 or more and uses only legal slope distances. A scoreboard model computes the expected header, data and measurement items from the sample history. The stimulus includes slopes exactly at the threshold, gaps in the strobe, and a second pulse inside an open window.

// File: rtl/pm_disc.sv
module pm_disc #(
  parameter int SW      = 12,
  parameter int MAX_GAP = 8,
  parameter int MAX_PRE = 7,
  parameter int CW      = 8,
  parameter int CHW     = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [CHW-1:0]                    chan_id,
  input  logic [$clog2(MAX_GAP+1)-1:0]      cfg_gap,
  input  logic [SW-1:0]                     cfg_thresh,
  input  logic [$clog2(MAX_PRE+1)-1:0]      cfg_pre,
  input  logic [CW-1:0]                     cfg_post,
  input  logic                              smp_valid,
  input  logic [SW-1:0]                     smp_data,
  output logic                              out_valid,
  output logic                              out_hdr,
  output logic                              out_last,
  output logic [2*SW-1:0]                   out_data,
  output logic                              meas_valid,
  output logic [SW-1:0]                     meas_peak,
  output logic [CW:0]                       meas_width
);
  localparam int DW  = 2*SW;
  localparam int TSW = DW - CHW;
  localparam int HD  = (MAX_GAP > MAX_PRE) ? MAX_GAP : MAX_PRE;
  localparam int HW  = (HD > 1) ? $clog2(HD) : 1;
  localparam int PW  = $clog2(MAX_PRE+1);
  localparam int LW  = CW + 1;

  logic [SW-1:0]  hist [HD];
  logic [TSW-1:0] ts;
  logic           busy, hold_v, wide;
  logic [PW-1:0]  pre_r;
  logic [LW-1:0]  len_r, cnt, wcnt;
  logic [SW-1:0]  held, peak;

  wire [PW-1:0]  pre_eff = busy ? pre_r : cfg_pre;
  wire [HW-1:0]  gap_idx = HW'(cfg_gap - 1'b1);
  wire [HW-1:0]  pre_idx = HW'(pre_eff - 1'b1);
  wire [SW-1:0]  tap     = (pre_eff == '0) ? smp_data : hist[pre_idx];

  wire signed [SW:0] diff  = $signed({1'b0, smp_data}) - $signed({1'b0, hist[gap_idx]});
  wire               above = diff > $signed({1'b0, cfg_thresh});
  wire               fire  = smp_valid && !busy && above;
  wire               last  = busy && (cnt == len_r - 1'b1);
  wire               post_s = busy && (cnt >= LW'(pre_r));
  wire               new_pk = post_s && (tap > peak);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < HD; k++) hist[k] <= '0;
      ts         <= '0;
      busy       <= 1'b0;
      hold_v     <= 1'b0;
      wide       <= 1'b0;
      pre_r      <= '0;
      len_r      <= '0;
      cnt        <= '0;
      wcnt       <= '0;
      held       <= '0;
      peak       <= '0;
      out_valid  <= 1'b0;
      out_hdr    <= 1'b0;
      out_last   <= 1'b0;
      out_data   <= '0;
      meas_valid <= 1'b0;
      meas_peak  <= '0;
      meas_width <= '0;
    end else begin
      out_valid  <= 1'b0;
      out_hdr    <= 1'b0;
      out_last   <= 1'b0;
      meas_valid <= 1'b0;
      if (smp_valid) begin
        hist[0] <= smp_data;
        for (int k = 1; k < HD; k++) hist[k] <= hist[k-1];
        ts <= ts + 1'b1;
        if (fire) begin
          busy      <= 1'b1;
          pre_r     <= cfg_pre;
          len_r     <= {1'b0, cfg_post} + LW'(cfg_pre);
          cnt       <= LW'(1);
          held      <= tap;
          hold_v    <= 1'b1;
          wide      <= 1'b1;
          wcnt      <= LW'(1);
          peak      <= (cfg_pre == '0) ? tap : '0;
          out_valid <= 1'b1;
          out_hdr   <= 1'b1;
          out_data  <= {chan_id, ts};
        end else if (busy) begin
          cnt <= cnt + 1'b1;
          if (new_pk) peak <= tap;
          if (wide && above) wcnt <= wcnt + 1'b1;
          else               wide <= 1'b0;
          if (hold_v) begin
            out_valid <= 1'b1;
            out_data  <= {held, tap};
            hold_v    <= 1'b0;
          end else if (last) begin
            out_valid <= 1'b1;
            out_data  <= {tap, {SW{1'b0}}};
          end else begin
            held   <= tap;
            hold_v <= 1'b1;
          end
          if (last) begin
            busy       <= 1'b0;
            out_last   <= 1'b1;
            meas_valid <= 1'b1;
            meas_peak  <= new_pk ? tap : peak;
            meas_width <= (wide && above) ? wcnt + 1'b1 : wcnt;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pm_disc_chk.sv
module pm_disc_chk #(
  parameter int CW = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        smp_valid,
  input logic        out_valid,
  input logic        out_hdr,
  input logic        out_last,
  input logic        meas_valid,
  input logic [CW:0] meas_width
);
  logic in_pkt;

  always_ff @(posedge clk) begin
    if (!rst_n) in_pkt <= 1'b0;
    else if (out_valid && out_hdr) in_pkt <= 1'b1;
    else if (out_valid && out_last) in_pkt <= 1'b0;
  end

  p_meas_with_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid |-> (out_valid && out_last));

  p_no_refire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hdr) |-> !in_pkt);

  p_data_in_pkt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hdr) |-> in_pkt);

  p_hdr_not_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hdr) |-> !out_last);

  p_needs_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> (!out_valid && !meas_valid));

  p_width_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid |-> (meas_width != '0));
endmodule

bind pm_disc pm_disc_chk #(.CW(CW)) u_pm_disc_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .out_valid(out_valid),
  .out_hdr(out_hdr), .out_last(out_last), .meas_valid(meas_valid),
  .meas_width(meas_width)
);

// File: tb/test_pm_disc.sv
module test_pm_disc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  chan_id = 8'h5A;
  logic [3:0]  cfg_gap = 4'd3;
  logic [11:0] cfg_thresh = 12'd40;
  logic [2:0]  cfg_pre = 3'd2;
  logic [7:0]  cfg_post = 8'd6;
  logic        smp_valid = 1'b0;
  logic [11:0] smp_data = '0;
  logic        out_valid, out_hdr, out_last, meas_valid;
  logic [23:0] out_data;
  logic [11:0] meas_peak;
  logic [8:0]  meas_width;

  always #5 clk = ~clk;

  pm_disc i_pm_disc (
    .clk(clk), .rst_n(rst_n), .chan_id(chan_id), .cfg_gap(cfg_gap),
    .cfg_thresh(cfg_thresh), .cfg_pre(cfg_pre), .cfg_post(cfg_post),
    .smp_valid(smp_valid), .smp_data(smp_data), .out_valid(out_valid),
    .out_hdr(out_hdr), .out_last(out_last), .out_data(out_data),
    .meas_valid(meas_valid), .meas_peak(meas_peak), .meas_width(meas_width)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [25:0] exp_q[$];
  logic [20:0] mexp_q[$];

  int xs[4096];
  bit ab[4096];
  int mi = 0, fi = 0, mL = 0, mpre = 0, mpost = 0, eprev = 0;
  bit mbusy = 1'b0;

  function automatic int getx(int j);
    return (j < 0) ? 0 : xs[j];
  endfunction

  task automatic model(int v);
    int d, k, e, pk, w;
    xs[mi] = v;
    d = v - getx(mi - int'(cfg_gap));
    ab[mi] = d > int'(cfg_thresh);
    if (!mbusy && ab[mi]) begin
      mbusy = 1'b1; fi = mi; mpre = cfg_pre; mpost = cfg_post; mL = mpre + mpost;
      exp_q.push_back({1'b1, 1'b0, chan_id, 16'(mi)});
    end
    if (mbusy) begin
      k = mi - fi;
      e = getx(fi - mpre + k);
      if (k % 2 == 1)    exp_q.push_back({1'b0, k == mL - 1, 12'(eprev), 12'(e)});
      else if (k == mL - 1) exp_q.push_back({1'b0, 1'b1, 12'(e), 12'd0});
      eprev = e;
      if (k == mL - 1) begin
        pk = 0;
        for (int j = fi; j < fi + mpost; j++) if (xs[j] > pk) pk = xs[j];
        w = 0;
        for (int j = fi; j < fi + mL; j++) begin
          if (!ab[j]) break;
          w++;
        end
        mexp_q.push_back({12'(pk), 9'(w)});
        mbusy = 1'b0;
      end
    end
    mi++;
  endtask

  task automatic sample(int v);
    model(v);
    smp_data = 12'(v);
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic base(int c);
    for (int j = 0; j < c; j++) sample(200 + ((j * 7) % 9) - 4);
  endtask

  task automatic pulse(int amp, int gaps);
    int sh[6];
    sh = '{amp / 4, amp, amp * 3 / 4, amp / 2, amp / 4, amp / 8};
    for (int j = 0; j < 6; j++) begin
      sample(200 + sh[j]);
      repeat (gaps) @(negedge clk);
    end
  endtask

  task automatic setcfg(int g, int t, int p, int q);
    cfg_gap = 4'(g); cfg_thresh = 12'(t); cfg_pre = 3'(p); cfg_post = 8'(q);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        n_cmp++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R9/R6: unexpected word hdr=%0b data=%h, expected none", out_hdr, out_data);
        end else begin
          logic [25:0] ex;
          ex = exp_q.pop_front();
          if ({out_hdr, out_last, out_data} !== ex) begin
            n_bad++;
            $display("FAIL %s: got hdr=%0b last=%0b data=%h, expected hdr=%0b last=%0b data=%h",
                     ex[25] ? "R2" : (ex[24] ? "R4/R5" : "R3"),
                     out_hdr, out_last, out_data, ex[25], ex[24], ex[23:0]);
          end
        end
      end
      if (meas_valid) begin
        n_cmp++;
        if (mexp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R7: unexpected measurement peak=%0d width=%0d, expected none", meas_peak, meas_width);
        end else begin
          logic [20:0] mx;
          mx = mexp_q.pop_front();
          if ({meas_peak, meas_width} !== mx) begin
            n_bad++;
            $display("FAIL R7/R8: got peak=%0d width=%0d, expected peak=%0d width=%0d",
                     meas_peak, meas_width, mx[20:9], mx[8:0]);
          end
        end
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_cmp++;
    if (out_valid !== 1'b0 || meas_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R10: out_valid=%0b meas_valid=%0b in reset, expected 0 0", out_valid, meas_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_cmp++;
    if (out_valid !== 1'b0 || meas_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R10: out_valid=%0b meas_valid=%0b after reset, expected 0 0", out_valid, meas_valid);
    end

    // R1: first sample sees a zeroed history and fires; then an even window (R3, R5)
    base(40);
    pulse(1000, 0);
    base(40);

    // R9: strobe gaps inside a pulse and between baseline samples
    pulse(700, 2);
    repeat (7) @(negedge clk);
    base(40);

    // R1: slope exactly at threshold does not fire, one above does
    for (int j = 0; j < 20; j++) sample(200);
    for (int j = 0; j < 20; j++) sample(240);
    for (int j = 0; j < 20; j++) sample(200);
    for (int j = 0; j < 15; j++) sample(241);
    for (int j = 0; j < 30; j++) sample(200);

    // R4: odd window length pads the last word
    setcfg(3, 60, 3, 6);
    base(20);
    pulse(1500, 0);
    base(40);

    // no pre-samples, slope over one sample
    setcfg(1, 50, 0, 5);
    base(20);
    pulse(900, 0);
    base(40);

    // R6: second pulse inside the open window does not fire
    setcfg(2, 40, 1, 12);
    base(20);
    pulse(800, 0);
    pulse(800, 0);
    base(40);

    // R6, R8: steady ramp fires again right after the window; width capped
    setcfg(1, 50, 0, 4);
    for (int j = 0; j < 12; j++) sample(200 + 100 * j);
    for (int j = 0; j < 30; j++) sample(200);

    // R7: full-scale peak with maximum pre-samples and minimum post
    setcfg(4, 100, 7, 2);
    base(20);
    pulse(3895, 0);
    base(40);

    // R9: slow drift below threshold produces nothing
    setcfg(3, 40, 2, 6);
    for (int j = 0; j < 60; j++) sample(200 + j * 5);
    for (int j = 0; j < 20; j++) sample(500);

    repeat (5) @(negedge clk);
    n_cmp++;
    if (exp_q.size() != 0 || mexp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R3/R7: %0d words and %0d measurements never appeared, expected 0 0",
               exp_q.size(), mexp_q.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule